// File: doc/BRIEF.md
# Display Refresh Window Address Generator

This block produces the stream of 32-bit word addresses that a display refresh DMA engine reads from memory. The visible window can sit anywhere inside a frame buffer that is larger than the screen. The window is described by five settings: a starting word address, the position of the first pixel inside that word, the screen line length and line count in words, and an extra stride that is added at every line end. The address stream uses a valid/ready handshake. It moves forward by one word per accepted transfer. At the end of each frame it wraps back to the first word of the window. A one-cycle end-of-frame pulse marks the wrap.

Software writes start addresses into shadow registers, one per panel. The frame currently being read is not disturbed by these writes. To move the window or swap buffers, software writes the shadows and then raises an update request. At the next frame boundary, every panel's shadow is copied into its active register at the same moment, and the request bit clears itself. A frame boundary is either the end of a frame or a start from idle. In dual-panel operation each frame first covers panel 0's window and then panel 1's window, so both pointers always change in the same frame. A frame pointer output shows the word currently being presented. Software can use it to judge how much of the frame remains.

When the 2D mode input is low, the stride and the pixel offset are ignored. The frame is then one contiguous run of memory.

Top module: `disp_fetch_addrgen`

## Requirements
- R1: After reset, addr_valid, eof_pulse and upd_pending are low and frame_ptr is 0. addr_valid stays low until enable is high.
- R2: With mode_2d low, a frame presents base, base+1, … for line_words×line_count consecutive words. line_inc has no effect.
- R3: With mode_2d high, line l, word w of a panel's window is at base + l×(line_words+line_inc) + w. With line_inc 0 the sequence equals the contiguous one.
- R4: With mode_2d high, addr_pix_off equals pix_off_cfg on the first word of every line and is 0 on the other words. With mode_2d low it is always 0.
- R5: The address advances only in a cycle where addr_valid and addr_ready are both high. Otherwise addr and frame_ptr hold.
- R6: The handshake on the last word of the frame returns the address to panel 0's active base. eof_pulse is high for exactly the one cycle in which that first word of the new frame is presented.
- R7: A base write (base_wr_en bit p with base_wr_data) changes only panel p's shadow. The addresses presented do not change while upd_pending is low, including across frame ends.
- R8: A upd_set pulse raises upd_pending. At the next frame boundary (end of frame, or start from idle) all shadows are copied to the active bases and upd_pending clears in that same cycle. If upd_set arrives in the boundary cycle itself, the request stays pending for the following boundary.
- R9: With dual_en high, each frame walks panel 0's window and then panel 1's window starting at panel 1's base. addr_panel gives the panel index (0 or 1). With dual_en low, only panel 0 is walked.
- R10: frame_ptr always equals the word address currently presented.
- R11: With enable low, addr_valid is low from the next cycle. A later start begins at word 0 of line 0 of panel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the address stream |
| mode_2d | input | 1 | Apply stride and pixel offset |
| dual_en | input | 1 | Walk two panel windows per frame |
| pix_off_cfg | input | PW (5) | First-pixel position inside the first word of a line |
| line_inc | input | IW (16) | Extra words skipped at each line end |
| line_words | input | LW (12) | Words per screen line |
| line_count | input | CW (12) | Lines per panel |
| base_wr_en | input | NP (2) | Per-panel shadow base write strobe |
| base_wr_data | input | AW (30) | Word address written to the shadow |
| upd_set | input | 1 | Request a shadow-to-active copy at the next boundary |
| addr_valid | output | 1 | Address output is valid |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | AW (30) | Word address being fetched |
| addr_panel | output | PNW (1) | Panel that owns the current address |
| addr_pix_off | output | PW (5) | Pixel offset for the current word |
| frame_ptr | output | AW (30) | Frame pointer readback |
| eof_pulse | output | 1 | First word of a new frame after a frame end |
| upd_pending | output | 1 | Update request waiting for a boundary |

## Verification
Some rules are checked by properties on every cycle: the address holds while stalled, valid drops once enable is low, the end-of-frame pulse only appears on a valid panel-0 word, the pending bit is cleared when the pulse is raised, the pixel offset is zero in contiguous mode, and the panel index stays at zero with one panel. The directed scenarios cover what needs a reference walk over a whole frame. They compute the exact address sequence for contiguous, strided and zero-stride windows, the offset on each line's first word, and the transition into panel 1. They also show that shadow writes stay invisible until a request is committed at a boundary.

// File: rtl/disp_fetch_pkg.sv
package disp_fetch_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_ph_e;

    // Kind of step taken on an accepted word
    typedef enum logic [1:0] {
        STEP_WORD  = 2'd0,
        STEP_LINE  = 2'd1,
        STEP_PANEL = 2'd2,
        STEP_FRAME = 2'd3
    } step_e;

endpackage

// File: rtl/disp_base_shadow.sv
module disp_base_shadow #(
    parameter int AW = 30,
    parameter int NP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          wr_en,
    input  logic [AW-1:0]          wr_data,
    input  logic                   upd_set,
    input  logic                   commit,
    output logic [NP-1:0][AW-1:0]  active_base,
    output logic [NP-1:0][AW-1:0]  next_base,
    output logic                   pending
);

    typedef struct packed {
        logic [NP-1:0][AW-1:0] shadow;
        logic [NP-1:0][AW-1:0] active;
        logic                  pend;
    } shd_t;

    shd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NP; p++) begin
            if (wr_en[p]) begin
                st_d.shadow[p] = wr_data;
            end
        end
        if (commit && st_q.pend) begin
            st_d.active = st_q.shadow;
            st_d.pend   = 1'b0;
        end
        if (upd_set) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_base = st_q.active;
    assign next_base   = st_q.pend ? st_q.shadow : st_q.active;
    assign pending     = st_q.pend;

endmodule

// File: rtl/disp_line_walker.sv
module disp_line_walker
    import disp_fetch_pkg::*;
#(
    parameter int AW  = 30,
    parameter int PW  = 5,
    parameter int IW  = 16,
    parameter int LW  = 12,
    parameter int CW  = 12,
    parameter int NP  = 2,
    parameter int PNW = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   mode_2d,
    input  logic                   dual_en,
    input  logic [PW-1:0]          pix_off_cfg,
    input  logic [IW-1:0]          line_inc,
    input  logic [LW-1:0]          line_words,
    input  logic [CW-1:0]          line_count,
    input  logic [NP-1:0][AW-1:0]  active_base,
    input  logic [NP-1:0][AW-1:0]  next_base,
    input  logic                   out_ready,
    output logic                   frame_bound,
    output logic                   out_valid,
    output logic [AW-1:0]          out_addr,
    output logic [PNW-1:0]         out_panel,
    output logic [PW-1:0]          out_pix_off,
    output logic                   out_eof
);

    localparam logic [PNW-1:0] LAST_PANEL = PNW'(NP - 1);

    typedef struct packed {
        walk_ph_e       ph;
        logic [AW-1:0]  addr;
        logic [LW-1:0]  word;
        logic [CW-1:0]  line;
        logic [PNW-1:0] panel;
        logic           first;
        logic           eof;
    } walk_t;

    walk_t st_d, st_q;

    logic [LW:0]    word_nx;
    logic [CW:0]    line_nx;
    logic [PNW-1:0] panel_nx;
    logic           last_word;
    logic           last_line;
    logic           last_panel;
    logic [AW-1:0]  stride;
    step_e          step;

    always_comb begin
        word_nx    = {1'b0, st_q.word} + 1'b1;
        line_nx    = {1'b0, st_q.line} + 1'b1;
        panel_nx   = st_q.panel + 1'b1;
        last_word  = word_nx >= {1'b0, line_words};
        last_line  = line_nx >= {1'b0, line_count};
        last_panel = !dual_en || (st_q.panel == LAST_PANEL);
        stride     = mode_2d ? AW'(line_inc) : '0;

        if (!last_word) begin
            step = STEP_WORD;
        end else if (!last_line) begin
            step = STEP_LINE;
        end else if (!last_panel) begin
            step = STEP_PANEL;
        end else begin
            step = STEP_FRAME;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.eof    = 1'b0;
        frame_bound = 1'b0;

        if (!enable) begin
            st_d = '0;
        end else if (st_q.ph == WALK_IDLE) begin
            st_d.ph     = WALK_RUN;
            st_d.addr   = next_base[0];
            st_d.word   = '0;
            st_d.line   = '0;
            st_d.panel  = '0;
            st_d.first  = 1'b1;
            frame_bound = 1'b1;
        end else if (out_ready) begin
            unique case (step)
                STEP_WORD: begin
                    st_d.addr  = st_q.addr + 1'b1;
                    st_d.word  = word_nx[LW-1:0];
                    st_d.first = 1'b0;
                end
                STEP_LINE: begin
                    st_d.addr  = st_q.addr + 1'b1 + stride;
                    st_d.word  = '0;
                    st_d.line  = line_nx[CW-1:0];
                    st_d.first = 1'b1;
                end
                STEP_PANEL: begin
                    st_d.addr  = active_base[panel_nx];
                    st_d.word  = '0;
                    st_d.line  = '0;
                    st_d.panel = panel_nx;
                    st_d.first = 1'b1;
                end
                default: begin
                    st_d.addr   = next_base[0];
                    st_d.word   = '0;
                    st_d.line   = '0;
                    st_d.panel  = '0;
                    st_d.first  = 1'b1;
                    st_d.eof    = 1'b1;
                    frame_bound = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = (st_q.ph == WALK_RUN);
    assign out_addr    = st_q.addr;
    assign out_panel   = st_q.panel;
    assign out_pix_off = (mode_2d && st_q.first && out_valid) ? pix_off_cfg : '0;
    assign out_eof     = st_q.eof;

endmodule

// File: rtl/disp_fetch_addrgen.sv
module disp_fetch_addrgen #(
    parameter int AW  = 30,
    parameter int PW  = 5,
    parameter int IW  = 16,
    parameter int LW  = 12,
    parameter int CW  = 12,
    parameter int NP  = 2,
    parameter int PNW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           mode_2d,
    input  logic           dual_en,
    input  logic [PW-1:0]  pix_off_cfg,
    input  logic [IW-1:0]  line_inc,
    input  logic [LW-1:0]  line_words,
    input  logic [CW-1:0]  line_count,
    input  logic [NP-1:0]  base_wr_en,
    input  logic [AW-1:0]  base_wr_data,
    input  logic           upd_set,
    output logic           addr_valid,
    input  logic           addr_ready,
    output logic [AW-1:0]  addr,
    output logic [PNW-1:0] addr_panel,
    output logic [PW-1:0]  addr_pix_off,
    output logic [AW-1:0]  frame_ptr,
    output logic           eof_pulse,
    output logic           upd_pending
);

    logic [NP-1:0][AW-1:0] active_base;
    logic [NP-1:0][AW-1:0] next_base;
    logic                  frame_bound;

    disp_base_shadow #(
        .AW (AW),
        .NP (NP)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (base_wr_en),
        .wr_data     (base_wr_data),
        .upd_set     (upd_set),
        .commit      (frame_bound),
        .active_base (active_base),
        .next_base   (next_base),
        .pending     (upd_pending)
    );

    disp_line_walker #(
        .AW  (AW),
        .PW  (PW),
        .IW  (IW),
        .LW  (LW),
        .CW  (CW),
        .NP  (NP),
        .PNW (PNW)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .mode_2d     (mode_2d),
        .dual_en     (dual_en),
        .pix_off_cfg (pix_off_cfg),
        .line_inc    (line_inc),
        .line_words  (line_words),
        .line_count  (line_count),
        .active_base (active_base),
        .next_base   (next_base),
        .out_ready   (addr_ready),
        .frame_bound (frame_bound),
        .out_valid   (addr_valid),
        .out_addr    (addr),
        .out_panel   (addr_panel),
        .out_pix_off (addr_pix_off),
        .out_eof     (eof_pulse)
    );

    assign frame_ptr = addr;

endmodule

// File: rtl/disp_fetch_chk.sv
module disp_fetch_chk #(
    parameter int AW  = 30,
    parameter int PW  = 5,
    parameter int PNW = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable,
    input logic           mode_2d,
    input logic           dual_en,
    input logic           upd_set,
    input logic           addr_valid,
    input logic           addr_ready,
    input logic [AW-1:0]  addr,
    input logic [PNW-1:0] addr_panel,
    input logic [PW-1:0]  addr_pix_off,
    input logic           eof_pulse,
    input logic           upd_pending
);

    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready && enable |=> addr_valid && $stable(addr));

    a_r11_stop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !addr_valid);

    a_r6_eof_on_panel0: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |-> addr_valid && addr_panel == '0);

    a_r8_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse && !$past(upd_set) |-> !upd_pending);

    a_r4_flat_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !mode_2d |-> addr_pix_off == '0);

    a_r9_single_panel: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !dual_en && $past(!dual_en) |-> addr_panel == '0);

endmodule

bind disp_fetch_addrgen disp_fetch_chk #(
    .AW  (AW),
    .PW  (PW),
    .PNW (PNW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .mode_2d      (mode_2d),
    .dual_en      (dual_en),
    .upd_set      (upd_set),
    .addr_valid   (addr_valid),
    .addr_ready   (addr_ready),
    .addr         (addr),
    .addr_panel   (addr_panel),
    .addr_pix_off (addr_pix_off),
    .eof_pulse    (eof_pulse),
    .upd_pending  (upd_pending)
);

// File: tb/sim_disp_fetch_addrgen.sv
`timescale 1ns/1ps
module sim_disp_fetch_addrgen;

    localparam int AW = 30, PW = 5, IW = 16, LW = 12, CW = 12, NP = 2, PNW = 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b0, mode_2d = 1'b0, dual_en = 1'b0;
    logic [PW-1:0]  pix_off_cfg = '0;
    logic [IW-1:0]  line_inc = '0;
    logic [LW-1:0]  line_words = '0;
    logic [CW-1:0]  line_count = '0;
    logic [NP-1:0]  base_wr_en = '0;
    logic [AW-1:0]  base_wr_data = '0;
    logic           upd_set = 1'b0;
    logic           addr_ready = 1'b1;
    logic           addr_valid, eof_pulse, upd_pending;
    logic [AW-1:0]  addr, frame_ptr;
    logic [PNW-1:0] addr_panel;
    logic [PW-1:0]  addr_pix_off;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    disp_fetch_addrgen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_2d(mode_2d), .dual_en(dual_en),
        .pix_off_cfg(pix_off_cfg), .line_inc(line_inc), .line_words(line_words),
        .line_count(line_count), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .upd_set(upd_set), .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
        .addr_panel(addr_panel), .addr_pix_off(addr_pix_off), .frame_ptr(frame_ptr),
        .eof_pulse(eof_pulse), .upd_pending(upd_pending)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_base(input int p, input logic [AW-1:0] v);
        @(negedge clk);
        base_wr_en = '0;
        base_wr_en[p] = 1'b1;
        base_wr_data = v;
        @(negedge clk);
        base_wr_en = '0;
    endtask

    task automatic pulse_upd();
        @(negedge clk);
        upd_set = 1'b1;
        @(negedge clk);
        upd_set = 1'b0;
    endtask

    task automatic set_cfg(input bit m2d, input bit dual, input int off, input int inc,
                           input int lw, input int lc);
        mode_2d = m2d; dual_en = dual; pix_off_cfg = PW'(off);
        line_inc = IW'(inc); line_words = LW'(lw); line_count = CW'(lc);
    endtask

    task automatic start();
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic stop(input string req);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!addr_valid, req, addr_valid, 0);
    endtask

    // Walk one frame from the reference formula; expects addr_ready high
    task automatic run_frame(input string req, input longint b0, input longint b1,
                             input int panels, input int lw, input int lc,
                             input int extra, input int off, input bit eof_first,
                             input bit skip_first);
        for (int p = 0; p < panels; p++) begin
            for (int l = 0; l < lc; l++) begin
                for (int w = 0; w < lw; w++) begin
                    longint ea;
                    bit     head;
                    head = (p == 0 && l == 0 && w == 0);
                    if (head && skip_first) continue;
                    @(negedge clk);
                    ea = ((p == 0) ? b0 : b1) + l * (lw + extra) + w;
                    chk(addr_valid && addr == AW'(ea), req, addr, ea);
                    chk(frame_ptr == AW'(ea), {req, "/R10"}, frame_ptr, ea);
                    chk(addr_pix_off == PW'((w == 0) ? off : 0), {req, "/R4"},
                        addr_pix_off, (w == 0) ? off : 0);
                    chk(addr_panel == PNW'(p), {req, "/R9"}, addr_panel, p);
                    chk(eof_pulse == (head && eof_first), {req, "/R6"}, eof_pulse,
                        head && eof_first);
                end
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!addr_valid && !eof_pulse && !upd_pending && frame_ptr == 0, "R1",
            {addr_valid, eof_pulse, upd_pending}, 0);
    endtask

    task automatic t_contig();
        set_cfg(0, 0, 5, 7, 4, 3);
        write_base(0, 30'h100);
        pulse_upd();
        chk(upd_pending, "R8 pending set", upd_pending, 1);
        start();
        run_frame("R2", 30'h100, 0, 1, 4, 3, 0, 0, 0, 0);
        chk(!upd_pending, "R8 commit at start", upd_pending, 0);
        run_frame("R6", 30'h100, 0, 1, 4, 3, 0, 0, 1, 0);
        stop("R11");
    endtask

    task automatic t_stride();
        set_cfg(1, 0, 3, 6, 5, 4);
        start();
        run_frame("R3", 30'h100, 0, 1, 5, 4, 6, 3, 0, 0);
        run_frame("R3 wrap", 30'h100, 0, 1, 5, 4, 6, 3, 1, 0);
        stop("R11");
        set_cfg(1, 0, 0, 0, 4, 3);
        start();
        run_frame("R3 zero stride", 30'h100, 0, 1, 4, 3, 0, 0, 0, 0);
        stop("R11");
    endtask

    task automatic t_shadow();
        set_cfg(0, 0, 0, 0, 4, 2);
        start();
        @(negedge clk);
        chk(addr == 30'h100, "R11 restart", addr, 30'h100);
        addr_ready = 1'b0;
        write_base(0, 30'h900);
        @(negedge clk);
        chk(addr == 30'h100 && frame_ptr == 30'h100, "R5 stall hold", addr, 30'h100);
        addr_ready = 1'b1;
        run_frame("R7", 30'h100, 0, 1, 4, 2, 0, 0, 0, 1);
        run_frame("R7 no pending", 30'h100, 0, 1, 4, 2, 0, 0, 1, 0);
        addr_ready = 1'b0;
        pulse_upd();
        chk(upd_pending && addr == 30'h100 + 7, "R8 pending mid-frame", addr, 30'h107);
        addr_ready = 1'b1;
        run_frame("R8", 30'h900, 0, 1, 4, 2, 0, 0, 1, 0);
        chk(!upd_pending, "R8 cleared at eof", upd_pending, 1'b0);
        stop("R11");
    endtask

    task automatic t_dual();
        set_cfg(1, 1, 1, 2, 3, 2);
        write_base(1, 30'h2000);
        pulse_upd();
        start();
        run_frame("R9", 30'h900, 30'h2000, 2, 3, 2, 2, 1, 0, 0);
        run_frame("R9 wrap", 30'h900, 30'h2000, 2, 3, 2, 2, 1, 1, 0);
        stop("R11");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_contig();
                t_stride();
                t_shadow();
                t_dual();
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule